// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single compare channel for a multi-channel event timer. A free-running main counter is shared by all channels. The channel holds a comparator value and emits a one-cycle fire strobe when the counter reaches that value. Interrupt routing, status bits and bus decoding sit outside the block. The block sees only write strobes for its configuration word and for the low and high halves of its comparator.

In one-shot mode the channel fires once and then stays quiet until it is armed again. In periodic mode a hidden period register is added to the comparator at each hit. If the counter has run several periods ahead, the channel fires once and steps forward until the comparator leads the counter again. A narrow mode restricts the comparator, the period and the compare to the low half of the counter. In narrow one-shot mode the channel also fires once when the low half of the counter rolls over before the match.

Top module: `evt_cmp_chan`

## Requirements
- R1: After reset `fire_o` is 0, `cmp_o` is all ones and `cfg_o` is 0.
- R2: In one-shot mode (config bit 1 clear) an armed channel fires exactly one single-cycle pulse. The pulse is visible in the cycle after the clock edge at which `cnt_i` equals the comparator.
- R3: If the counter is already at or past the comparator when the channel is armed, the channel fires on the first clock edge after arming.
- R4: In periodic mode (config bit 1 set) with a non-zero period, every hit adds the period to the comparator. With a counter that steps by one, consecutive pulses are exactly one period apart.
- R5: If the counter has passed several periods when a periodic hit occurs, only one pulse is produced. The comparator then advances until it is ahead of that counter value.
- R6: In periodic mode a comparator write loads the hidden period. The write also changes the visible comparator only when the set-value bit (config bit 2) is set. The set-value bit reads back 0 after any comparator write.
- R7: In periodic mode a written period has its top bit forced to 0. This is bit 31 of a low-half write in narrow mode, and bit 63 (a high-half write) otherwise.
- R8: Writing the configuration with the narrow bit (config bit 3) set clears the upper half of the comparator and of the period. In narrow mode, high-half comparator writes are ignored, and "reached" is the sign of the low-half difference counter minus comparator.
- R9: In narrow one-shot mode the channel gives one extra pulse when the low half of the counter wraps to zero before the match. The match pulse follows later. In wide mode no wrap pulse occurs.
- R10: The channel fires only while both the channel enable (config bit 0) and `glb_en_i` are 1. Three events arm the channel: setting bit 0 while the global enable is on, a comparator write while both enables are on, and a rising global enable while bit 0 is set and the comparator is not all ones. Clearing either enable disarms the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Shared main counter value |
| glb_en_i | input | 1 | Global timer enable |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | CFG_W | Configuration write data: bit0 enable, bit1 periodic, bit2 set-value, bit3 narrow |
| cmp_lo_we_i | input | 1 | Comparator low-half write strobe |
| cmp_hi_we_i | input | 1 | Comparator high-half write strobe |
| wdata_i | input | HALF_W | Comparator write data |
| fire_o | output | 1 | Single-cycle event strobe |
| cmp_o | output | CNT_W | Comparator readback |
| cfg_o | output | CFG_W | Configuration readback |

## Verification
The bench drives the counter directly. This lets it run periodic sweeps for periods one to five, where a period of one fires on every cycle and exposes any design that needs a dead cycle to re-evaluate after advancing. A counter jump far past the comparator checks that a design without catch-up suppression, which would fire once per missed period, gives a single pulse and lands on the next period boundary. Further cases place counter upper bits far from the comparator in narrow mode, where a wide compare would fire at once, and run a low-half rollover in both modes to show the wrap pulse appears only in narrow one-shot. The masked period top bit is observed through the comparator value after a hit.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;
  localparam int CFG_W   = 4;
  localparam int CFG_EN  = 0;
  localparam int CFG_PER = 1;
  localparam int CFG_SET = 2;
  localparam int CFG_M32 = 3;
endpackage

// File: rtl/evt_cmp_reach.sv
// Signed "now has reached target" test, full width or low half.
module evt_cmp_reach #(
  parameter int W = 64,
  parameter int H = W / 2
) (
  input  logic [W-1:0] now_i,
  input  logic [W-1:0] tgt_i,
  input  logic         narrow_i,
  output logic         reached_o
);
  logic [W-1:0] d_full;
  logic [H-1:0] d_half;

  assign d_full    = now_i - tgt_i;
  assign d_half    = now_i[H-1:0] - tgt_i[H-1:0];
  assign reached_o = narrow_i ? ~d_half[H-1] : ~d_full[W-1];
endmodule

// File: rtl/evt_cmp_wrap.sv
// Flags a rollover of the low half of the counter.
module evt_cmp_wrap #(
  parameter int H = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [H-1:0] lo_i,
  output logic         wrap_o
);
  logic [H-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lo_i;
  end

  assign wrap_o = lo_i < prev_q;
endmodule

// File: rtl/evt_cmp_chan.sv
module evt_cmp_chan
  import evt_cmp_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int HALF_W = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              glb_en_i,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              cmp_lo_we_i,
  input  logic              cmp_hi_we_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic              fire_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CFG_W-1:0]  cfg_o
);
  localparam logic [HALF_W-1:0] NO_MSB = {1'b0, {(HALF_W-1){1'b1}}};

  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cmp_q, per_q, tgt_q;
  logic             armed_q, wrap_q, catch_q, fire_q, glb_q;

  logic ch_en, per_mode, set_arm, m32, per_nz, cmp_wr;
  logic live_en, reached, catch_more, wrapped;
  logic hit, wrap_hit, step;
  logic [CNT_W-1:0] cmp_sum, tgt_sel;

  assign ch_en    = cfg_q[CFG_EN];
  assign per_mode = cfg_q[CFG_PER];
  assign set_arm  = cfg_q[CFG_SET];
  assign m32      = cfg_q[CFG_M32];
  assign per_nz   = |per_q;
  assign cmp_wr   = cmp_lo_we_i | cmp_hi_we_i;
  assign live_en  = armed_q & glb_en_i & ch_en;

  always_comb begin
    cmp_sum = cmp_q + per_q;
    if (m32) cmp_sum[CNT_W-1:HALF_W] = '0;
  end

  // catch-up compares the advanced comparator against the counter sampled at the hit
  assign tgt_sel = catch_q ? tgt_q : cnt_i;

  evt_cmp_reach #(.W(CNT_W), .H(HALF_W)) u_reach_live (
    .now_i(cnt_i), .tgt_i(cmp_q), .narrow_i(m32), .reached_o(reached)
  );

  evt_cmp_reach #(.W(CNT_W), .H(HALF_W)) u_reach_catch (
    .now_i(tgt_sel), .tgt_i(cmp_sum), .narrow_i(m32), .reached_o(catch_more)
  );

  evt_cmp_wrap #(.H(HALF_W)) u_wrap (
    .clk_i(clk_i), .rst_ni(rst_ni), .lo_i(cnt_i[HALF_W-1:0]), .wrap_o(wrapped)
  );

  assign hit      = live_en & reached & ~catch_q;
  assign wrap_hit = live_en & m32 & ~per_mode & wrapped & ~wrap_q & ~reached & ~catch_q;
  assign step     = live_en & per_mode & per_nz & (hit | catch_q) & ~cmp_wr & ~cfg_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      cmp_q   <= '1;
      per_q   <= '0;
      tgt_q   <= '0;
      armed_q <= 1'b0;
      wrap_q  <= 1'b0;
      catch_q <= 1'b0;
      fire_q  <= 1'b0;
      glb_q   <= 1'b0;
    end else begin
      fire_q <= hit | wrap_hit;
      glb_q  <= glb_en_i;

      if (step) begin
        cmp_q   <= cmp_sum;
        catch_q <= catch_more;
      end else begin
        catch_q <= 1'b0;
      end
      if (hit) tgt_q <= cnt_i;
      if (hit && !(per_mode && per_nz)) armed_q <= 1'b0;
      if (wrap_hit) wrap_q <= 1'b1;

      if (cfg_we_i) begin
        cfg_q <= cfg_wdata_i;
        if (cfg_wdata_i[CFG_M32]) begin
          cmp_q[CNT_W-1:HALF_W] <= '0;
          per_q[CNT_W-1:HALF_W] <= '0;
        end
        if (cfg_wdata_i[CFG_EN] && !ch_en && glb_en_i) begin
          armed_q <= 1'b1;
          wrap_q  <= 1'b0;
          catch_q <= 1'b0;
        end else if (!cfg_wdata_i[CFG_EN] && ch_en) begin
          armed_q <= 1'b0;
          catch_q <= 1'b0;
        end
      end

      if (cmp_wr) begin
        cfg_q[CFG_SET] <= 1'b0;
        if (cmp_lo_we_i) begin
          if (!per_mode || set_arm) cmp_q[HALF_W-1:0] <= wdata_i;
          if (per_mode) per_q[HALF_W-1:0] <= m32 ? (wdata_i & NO_MSB) : wdata_i;
        end
        if (cmp_hi_we_i && !m32) begin
          if (!per_mode || set_arm) cmp_q[CNT_W-1:HALF_W] <= wdata_i;
          if (per_mode) per_q[CNT_W-1:HALF_W] <= wdata_i & NO_MSB;
        end
        if (ch_en && glb_en_i) begin
          armed_q <= 1'b1;
          wrap_q  <= 1'b0;
          catch_q <= 1'b0;
        end
      end

      if (glb_en_i && !glb_q && ch_en && cmp_q != '1) begin
        armed_q <= 1'b1;
        wrap_q  <= 1'b0;
        catch_q <= 1'b0;
      end else if (!glb_en_i && glb_q) begin
        armed_q <= 1'b0;
        catch_q <= 1'b0;
      end
    end
  end

  assign fire_o = fire_q;
  assign cmp_o  = cmp_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/evt_cmp_chan_chk.sv
module evt_cmp_chan_chk
  import evt_cmp_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int HALF_W = CNT_W / 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             glb_en_i,
  input logic             cfg_we_i,
  input logic             cmp_lo_we_i,
  input logic             cmp_hi_we_i,
  input logic             fire_o,
  input logic [CNT_W-1:0] cmp_o,
  input logic [CFG_W-1:0] cfg_o
);
  AST_FIRE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> ($past(glb_en_i) && $past(cfg_o[CFG_EN]))); // R10

  AST_SET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmp_lo_we_i || cmp_hi_we_i) && !cfg_we_i) |=> !cfg_o[CFG_SET]); // R6

  AST_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_lo_we_i && !cmp_hi_we_i && !cfg_we_i && cfg_o[CFG_PER] && !cfg_o[CFG_SET])
      |=> (cmp_o == $past(cmp_o))); // R6

  AST_NARROW_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[CFG_M32] |-> (cmp_o[CNT_W-1:HALF_W] == '0)); // R8

  AST_ONESHOT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !cfg_o[CFG_PER] && !cfg_o[CFG_M32] && !$past(cfg_o[CFG_PER])
      && !$past(cmp_lo_we_i || cmp_hi_we_i)) |=> !fire_o); // R2
endmodule

bind evt_cmp_chan evt_cmp_chan_chk #(.CNT_W(CNT_W), .HALF_W(HALF_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .glb_en_i(glb_en_i), .cfg_we_i(cfg_we_i),
  .cmp_lo_we_i(cmp_lo_we_i), .cmp_hi_we_i(cmp_hi_we_i),
  .fire_o(fire_o), .cmp_o(cmp_o), .cfg_o(cfg_o)
);

// File: tb/evt_cmp_chan_tb_top.sv
module evt_cmp_chan_tb_top;
  localparam logic [3:0] EN = 4'b0001, PER = 4'b0010, SETV = 4'b0100, M32 = 4'b1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        glb_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wd = '0;
  logic        lo_we = 1'b0, hi_we = 1'b0;
  logic [31:0] wd = '0;
  logic        fire;
  logic [63:0] cmp;
  logic [3:0]  cfg;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int fires;
  logic [63:0] first_at, second_at;

  always #2 clk = ~clk;

  evt_cmp_chan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .glb_en_i(glb_en),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cmp_lo_we_i(lo_we), .cmp_hi_we_i(hi_we),
    .wdata_i(wd), .fire_o(fire), .cmp_o(cmp), .cfg_o(cfg)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wcfg(input logic [3:0] v);
    @(negedge clk); cfg_wd = v; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wlo(input logic [31:0] v);
    @(negedge clk); wd = v; lo_we = 1'b1;
    @(negedge clk); lo_we = 1'b0;
  endtask

  task automatic whi(input logic [31:0] v);
    @(negedge clk); wd = v; hi_we = 1'b1;
    @(negedge clk); hi_we = 1'b0;
  endtask

  // each counter value is seen by one edge; the pulse is sampled at the next negedge
  task automatic run(input logic [63:0] start, input logic [63:0] stp, input int n);
    fires = 0; first_at = '1; second_at = '1;
    for (int i = 0; i < n; i++) begin
      cnt = start + 64'(i) * stp;
      @(negedge clk);
      if (fire) begin
        if (fires == 0) first_at = cnt;
        else if (fires == 1) second_at = cnt;
        fires++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 fire", 64'(fire), 64'd0);
    chk("R1 cmp", cmp, '1);
    chk("R1 cfg", 64'(cfg), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    glb_en = 1'b1;

    // R2 one-shot sweep
    cnt = 64'd100;
    whi(32'd0);
    for (int k = 0; k < 6; k++) begin
      wcfg(4'd0);
      wlo(32'd103 + 32'(k));
      wcfg(EN);
      run(64'd100, 64'd1, 20);
      chk("R2 count", 64'(fires), 64'd1);
      chk("R2 position", first_at, 64'd103 + 64'(k));
    end

    // R3 comparator already behind
    cnt = 64'd500;
    wcfg(4'd0); wlo(32'd100); wcfg(EN);
    run(64'd500, 64'd0, 3);
    chk("R3 count", 64'(fires), 64'd1);
    chk("R3 position", first_at, 64'd500);

    // R4/R6 periodic sweep
    for (int p = 1; p <= 5; p++) begin
      cnt = 64'd190;
      wcfg(4'd0);
      wcfg(PER | SETV);
      wlo(32'd200);
      chk("R6 set-value write", cmp, 64'd200);
      chk("R6 set-value clear", 64'(cfg), 64'(PER));
      wlo(32'(p));
      chk("R6 period-only write", cmp, 64'd200);
      wcfg(PER | EN);
      run(64'd190, 64'd1, 40);
      chk("R4 count", 64'(fires), 64'(29 / p + 1));
      chk("R4 first", first_at, 64'd200);
      chk("R4 spacing", second_at, (p == 1 || 29 / p >= 1) ? 64'd200 + 64'(p) : '1);
      chk("R4 cmp after", cmp, 64'd200 + 64'((29 / p + 1) * p));
    end

    // R5 catch-up, period 4
    cnt = 64'd190;
    wcfg(4'd0); wcfg(PER | SETV); wlo(32'd200); wlo(32'd4); wcfg(PER | EN);
    run(64'd300, 64'd0, 30);
    chk("R5 single pulse", 64'(fires), 64'd1);
    chk("R5 cmp landed", cmp, 64'd304);
    run(64'd301, 64'd1, 10);
    chk("R5 resume count", 64'(fires), 64'd2);
    chk("R5 resume first", first_at, 64'd304);

    // R7/R8 narrow periodic, masked period
    cnt = 64'h9_0000_0000;
    wcfg(4'd0); wcfg(M32 | PER | SETV); wlo(32'd5); wlo(32'hFFFF_FFFF);
    wcfg(M32 | PER | EN);
    run(64'h9_0000_0000, 64'd1, 10);
    chk("R8 narrow compare", 64'(fires), 64'd1);
    chk("R8 narrow position", first_at, 64'h9_0000_0005);
    chk("R7 narrow msb", cmp, 64'h8000_0004);

    // R7 wide period top bit
    cnt = 64'd0;
    wcfg(4'd0); wcfg(PER | SETV); wlo(32'd10); whi(32'hFFFF_FFFF); wlo(32'd0);
    chk("R6 hi write period only", cmp, 64'd10);
    wcfg(PER | EN);
    run(64'd0, 64'd1, 15);
    chk("R7 wide count", 64'(fires), 64'd1);
    chk("R7 wide msb", cmp, 64'h7FFF_FFFF_0000_000A);

    // R8 truncation and ignored high writes
    wcfg(4'd0); whi(32'd1); wlo(32'h20);
    chk("R8 wide cmp", cmp, 64'h1_0000_0020);
    wcfg(M32);
    chk("R8 truncate", cmp, 64'h20);
    whi(32'd5);
    chk("R8 hi ignored", cmp, 64'h20);

    // R9 wrap pulse in narrow one-shot
    cnt = 64'h3_FFFF_FFF8;
    wlo(32'h10); wcfg(M32 | EN);
    run(64'h3_FFFF_FFF8, 64'd1, 32);
    chk("R9 narrow count", 64'(fires), 64'd2);
    chk("R9 wrap pulse", first_at, 64'h4_0000_0000);
    chk("R9 match pulse", second_at, 64'h4_0000_0010);

    // R9 no wrap pulse in wide mode
    wcfg(4'd0);
    cnt = 64'h3_FFFF_FFF8;
    whi(32'd4); wlo(32'h10); wcfg(EN);
    run(64'h3_FFFF_FFF8, 64'd1, 32);
    chk("R9 wide count", 64'(fires), 64'd1);
    chk("R9 wide position", first_at, 64'h4_0000_0010);

    // R10 enables
    @(negedge clk); glb_en = 1'b0;
    cnt = 64'h40;
    wcfg(4'd0); whi(32'd0); wlo(32'h50); wcfg(EN);
    run(64'h40, 64'd1, 32);
    chk("R10 global off", 64'(fires), 64'd0);
    cnt = 64'h40;
    @(negedge clk); glb_en = 1'b1;
    @(negedge clk);
    run(64'h40, 64'd1, 32);
    chk("R10 global rise arms", 64'(fires), 64'd1);
    chk("R10 global rise position", first_at, 64'h50);
    cnt = 64'h60;
    wcfg(4'd0); wlo(32'h70);
    run(64'h60, 64'd1, 32);
    chk("R10 channel off", 64'(fires), 64'd0);
    cnt = 64'h60;
    wcfg(EN);
    @(negedge clk); glb_en = 1'b0;
    run(64'h60, 64'd1, 32);
    chk("R10 global fall disarms", 64'(fires), 64'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule